// File: doc/BRIEF.md
# 1-Wire Bridge Command Controller

This block is the host-facing command engine of an I2C-to-1-Wire bridge. A bit-level I2C slave front end hands it start and stop events and a stream of received bytes. The first byte after each start carries the 7-bit address and the R/W flag. For every byte the controller returns an acknowledge decision. The controller recognises eight function commands, checks their parameters and holds the configuration, status and read-data registers. It also holds a read pointer that selects the register presented to the front end during read transfers. The timed 1-Wire work is requested from a separate sequencer through a start pulse with an operation code and a data byte, and the sequencer reports completion with a done pulse and its sampled results.

Received bytes enter over a valid/ready pair. `rx_ready` is low while an acknowledge decision is still waiting to be taken, so only one decision is ever outstanding. The decision is offered on `ack_valid`/`ack_bit` and is consumed when `ack_ready` is high. During a read transfer `tx_valid` stays high and `tx_data` carries the selected register, and the front end may sample it as often as it needs.

Top module: `owm_bridge_ctrl`

## Requirements
- R1: The device answers only to the 7-bit address 0b00110 followed by `ad_sel[1]` and `ad_sel[0]`. The address byte is that address shifted left once, with R/W (1 = read) in bit 0. A matching address byte is acknowledged (`ack_bit`=1). Any other address byte is refused (`ack_bit`=0), and every byte after it is refused until the next start.
- R2: After reset the read pointer selects status, status reads 10h (only the device-reset flag set), and configuration reads 00h.
- R3: Command E1h takes one pointer byte: F0h selects status, E1h selects read data, C3h selects configuration. Any other pointer byte is refused and leaves the pointer unchanged.
- R4: Command D2h takes one configuration byte, which is accepted only when bits 7:4 equal the bitwise inverse of bits 3:0. A byte that fails this check is refused and changes nothing. Bit 0 is active pullup, bit 2 is strong pullup and bit 3 is overdrive speed. Read-back returns those three bits in the same positions, with bit 1 and bits 7:4 as 0.
- R5: An accepted configuration write clears the device-reset flag (status bit 4) and moves the read pointer to configuration.
- R6: Commands B4h, 87h, A5h, 96h and 78h each produce one `ow_start` pulse and move the pointer to status. The `ow_op` values are 0 for bus reset, 1 for single bit, 2 for write byte, 3 for read byte and 4 for triplet. `ow_data` carries the parameter byte for 87h, A5h and 78h. Status bit 0 (busy) reads 1 from the start until the matching `ow_done`.
- R7: While busy is 1, D2h and all five 1-Wire commands are refused together with any parameter byte, and nothing starts. F0h and E1h are accepted while busy.
- R8: Command F0h is acknowledged. It pulses `ow_abort`, clears the configuration and all status bits except the device-reset flag, sets that flag, and points the pointer at status.
- R9: `ow_done` while busy updates status by operation. A bus reset updates bit 2 (short) and bit 1 (presence), and presence is forced to 0 when a short is reported. A single bit updates bit 5. A triplet updates bits 5, 6 and 7. A read byte stores `ow_res_byte` as read data. A done pulse while idle changes nothing.
- R10: An unknown command code is refused. After any refusal, and after a command has received all of its bytes, every further byte is refused until the next start.
- R11: Repeated reads within one read transfer return the same register without readdressing.
- R12: Status bit 3 takes the level of `ow_line` sampled when a read address byte is accepted while the pointer selects status. Later line changes within that transfer do not alter it.
- R13: An `ow_spu_end` pulse clears the strong-pullup bit and leaves active pullup and speed unchanged.
- R14: After a byte is taken, `ack_valid` rises on the next cycle and stays high, with `rx_ready` low, until `ack_ready` is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ad_sel | input | 2 | Address select pins |
| bus_start | input | 1 | Start or repeated-start event pulse |
| bus_stop | input | 1 | Stop event pulse |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Controller can take a byte |
| ack_valid | output | 1 | Acknowledge decision pending |
| ack_ready | input | 1 | Front end takes the decision |
| ack_bit | output | 1 | 1 = acknowledge, 0 = refuse |
| tx_valid | output | 1 | Read transfer in progress, tx_data meaningful |
| tx_data | output | 8 | Register selected by the read pointer |
| ow_start | output | 1 | One-cycle request to the 1-Wire sequencer |
| ow_op | output | 3 | Requested operation code |
| ow_data | output | 8 | Parameter byte for the operation |
| ow_abort | output | 1 | One-cycle abort on device reset |
| ow_done | input | 1 | Sequencer finished, results valid |
| ow_res_ppd | input | 1 | Presence detected |
| ow_res_sd | input | 1 | Short detected |
| ow_res_sbr | input | 1 | First sampled bit |
| ow_res_tsb | input | 1 | Second sampled bit of a triplet |
| ow_res_dir | input | 1 | Direction chosen by a triplet |
| ow_res_byte | input | 8 | Byte read from the bus |
| ow_spu_end | input | 1 | Strong pullup has ended |
| ow_line | input | 1 | Present 1-Wire line level |
| cfg_apu | output | 1 | Active pullup enable |
| cfg_spu | output | 1 | Strong pullup armed |
| cfg_ows | output | 1 | Overdrive speed select |

## Verification
The hardest state to reach is a command arriving while the sequencer is still working, because busy lasts only until the sequencer answers. The bench plays the sequencer itself and withholds `ow_done` for as long as it likes, so refused commands, device reset with abort, and pointer moves can all be driven into the busy window. A reference model tracks busy to predict each acknowledge. Random sequences mix valid and malformed configuration and pointer bytes, unknown codes, stray done pulses and strong-pullup end events, and each read of the pointed register is compared with the model.

// File: rtl/owm_pkg.sv
package owm_pkg;
  typedef enum logic [2:0] {
    OP_RESET = 3'd0, OP_BIT = 3'd1, OP_WBYTE = 3'd2, OP_RBYTE = 3'd3, OP_TRIP = 3'd4
  } ow_op_e;

  typedef enum logic [1:0] {PTR_STAT = 2'd0, PTR_DATA = 2'd1, PTR_CFG = 2'd2} rptr_e;

  typedef struct packed {
    logic ows;
    logic spu;
    logic apu;
  } cfg_t;

  localparam logic [7:0] CMD_DEVRST = 8'hF0;
  localparam logic [7:0] CMD_SETPTR = 8'hE1;
  localparam logic [7:0] CMD_WCFG   = 8'hD2;
  localparam logic [7:0] CMD_OWRST  = 8'hB4;
  localparam logic [7:0] CMD_BIT    = 8'h87;
  localparam logic [7:0] CMD_WBYTE  = 8'hA5;
  localparam logic [7:0] CMD_RBYTE  = 8'h96;
  localparam logic [7:0] CMD_TRIP   = 8'h78;

  localparam logic [7:0] PC_STAT = 8'hF0;
  localparam logic [7:0] PC_DATA = 8'hE1;
  localparam logic [7:0] PC_CFG  = 8'hC3;
endpackage

// File: rtl/owm_cmd_fsm.sv
module owm_cmd_fsm
  import owm_pkg::*;
#(
  parameter int AD_W = 2,
  parameter logic [6:0] ADDR_BASE = 7'b0011000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_sel,
  input  logic            bus_start,
  input  logic            bus_stop,
  input  logic            rx_valid,
  input  logic [7:0]      rx_data,
  output logic            rx_ready,
  output logic            ack_valid,
  input  logic            ack_ready,
  output logic            ack_bit,
  output logic            tx_valid,
  input  logic            busy,
  input  logic            ptr_is_stat,
  output logic            ev_devrst,
  output logic            ev_ptr,
  output rptr_e           ev_ptr_val,
  output logic            ev_cfg,
  output cfg_t            ev_cfg_val,
  output logic            ev_start,
  output ow_op_e          ev_op,
  output logic            ev_llsamp
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_PTR, S_CFG, S_OWP, S_READ, S_HOLD} st_e;

  st_e    st, st_d;
  ow_op_e pend, pend_d;
  logic   ack_d, acc, guarded;

  assign rx_ready = !ack_valid;
  assign acc      = rx_valid && rx_ready;
  assign tx_valid = (st == S_READ);
  assign guarded  = (rx_data == CMD_WCFG) || (rx_data == CMD_OWRST) || (rx_data == CMD_BIT) ||
                    (rx_data == CMD_WBYTE) || (rx_data == CMD_RBYTE) || (rx_data == CMD_TRIP);

  always_comb begin
    st_d = st;  pend_d = pend;  ack_d = 1'b0;
    ev_devrst = 1'b0;  ev_ptr = 1'b0;  ev_cfg = 1'b0;  ev_start = 1'b0;  ev_llsamp = 1'b0;
    ev_ptr_val = PTR_STAT;
    ev_op = pend;
    ev_cfg_val = '{ows: rx_data[3], spu: rx_data[2], apu: rx_data[0]};
    if (bus_start) st_d = S_ADDR;
    else if (bus_stop) st_d = S_IDLE;
    else if (acc) begin
      case (st)
        S_ADDR: begin
          if (rx_data[7:AD_W+1] == ADDR_BASE[6:AD_W] && rx_data[AD_W:1] == ad_sel) begin
            ack_d = 1'b1;
            if (rx_data[0]) begin
              st_d = S_READ;
              ev_llsamp = ptr_is_stat;
            end else st_d = S_CMD;
          end else st_d = S_IDLE;
        end
        S_CMD: begin
          st_d = S_HOLD;
          if (rx_data == CMD_DEVRST) begin
            ack_d = 1'b1;  ev_devrst = 1'b1;
          end else if (rx_data == CMD_SETPTR) begin
            ack_d = 1'b1;  st_d = S_PTR;
          end else if (guarded && !busy) begin
            ack_d = 1'b1;
            case (rx_data)
              CMD_WCFG:  st_d = S_CFG;
              CMD_OWRST: begin ev_start = 1'b1; ev_op = OP_RESET; end
              CMD_RBYTE: begin ev_start = 1'b1; ev_op = OP_RBYTE; end
              CMD_BIT:   begin st_d = S_OWP; pend_d = OP_BIT; end
              CMD_WBYTE: begin st_d = S_OWP; pend_d = OP_WBYTE; end
              default:   begin st_d = S_OWP; pend_d = OP_TRIP; end
            endcase
          end
        end
        S_PTR: begin
          st_d = S_HOLD;
          case (rx_data)
            PC_STAT: begin ack_d = 1'b1; ev_ptr = 1'b1; ev_ptr_val = PTR_STAT; end
            PC_DATA: begin ack_d = 1'b1; ev_ptr = 1'b1; ev_ptr_val = PTR_DATA; end
            PC_CFG:  begin ack_d = 1'b1; ev_ptr = 1'b1; ev_ptr_val = PTR_CFG;  end
            default: ;
          endcase
        end
        S_CFG: begin
          st_d = S_HOLD;
          if (rx_data[7:4] == ~rx_data[3:0]) begin
            ack_d = 1'b1;  ev_cfg = 1'b1;
          end
        end
        S_OWP: begin
          st_d = S_HOLD;  ack_d = 1'b1;  ev_start = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  pend <= OP_RESET;  ack_valid <= 1'b0;  ack_bit <= 1'b0;
    end else begin
      st <= st_d;
      pend <= pend_d;
      if (acc) begin
        ack_valid <= 1'b1;
        ack_bit   <= ack_d;
      end else if (ack_ready) ack_valid <= 1'b0;
    end
  end

  assert_ack_follows_R14: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ack_valid);
  assert_busy_refuse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CMD && acc && busy && guarded && !bus_start && !bus_stop) |=> (ack_valid && !ack_bit));
  assert_hold_nack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && acc && !bus_start && !bus_stop) |=> !ack_bit);
endmodule

// File: rtl/owm_regs.sv
module owm_regs
  import owm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_devrst,
  input  logic       ev_ptr,
  input  rptr_e      ev_ptr_val,
  input  logic       ev_cfg,
  input  cfg_t       ev_cfg_val,
  input  logic       ev_start,
  input  ow_op_e     ev_op,
  input  logic [7:0] ev_data,
  input  logic       ev_llsamp,
  input  logic       ow_done,
  input  logic       ow_res_ppd,
  input  logic       ow_res_sd,
  input  logic       ow_res_sbr,
  input  logic       ow_res_tsb,
  input  logic       ow_res_dir,
  input  logic [7:0] ow_res_byte,
  input  logic       ow_spu_end,
  input  logic       ow_line,
  output cfg_t       cfg,
  output logic [7:0] status,
  output logic [7:0] rdata,
  output rptr_e      ptr,
  output logic       busy,
  output logic       ow_start,
  output ow_op_e     ow_op,
  output logic [7:0] ow_data,
  output logic       ow_abort
);
  logic rst_f, ll, sd, ppd, sbr, tsb, dir;

  assign status = {dir, tsb, sbr, rst_f, ll, sd, ppd, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;  rst_f <= 1'b1;  busy <= 1'b0;  ll <= 1'b0;  sd <= 1'b0;  ppd <= 1'b0;
      sbr <= 1'b0;  tsb <= 1'b0;  dir <= 1'b0;  rdata <= '0;  ptr <= PTR_STAT;
      ow_start <= 1'b0;  ow_op <= OP_RESET;  ow_data <= '0;  ow_abort <= 1'b0;
    end else begin
      ow_start <= 1'b0;
      ow_abort <= 1'b0;
      if (ev_devrst) begin
        cfg <= '0;  rst_f <= 1'b1;  busy <= 1'b0;  ll <= 1'b0;  sd <= 1'b0;  ppd <= 1'b0;
        sbr <= 1'b0;  tsb <= 1'b0;  dir <= 1'b0;  ptr <= PTR_STAT;  ow_abort <= 1'b1;
      end else begin
        if (ev_cfg) begin
          cfg <= ev_cfg_val;  rst_f <= 1'b0;  ptr <= PTR_CFG;
        end else if (ow_spu_end) cfg.spu <= 1'b0;
        if (ev_ptr) ptr <= ev_ptr_val;
        if (ev_start) begin
          ow_start <= 1'b1;  ow_op <= ev_op;  ow_data <= ev_data;  busy <= 1'b1;  ptr <= PTR_STAT;
        end else if (ow_done && busy) begin
          busy <= 1'b0;
          case (ow_op)
            OP_RESET: begin sd <= ow_res_sd; ppd <= ow_res_ppd && !ow_res_sd; end
            OP_BIT:   sbr <= ow_res_sbr;
            OP_TRIP:  begin sbr <= ow_res_sbr; tsb <= ow_res_tsb; dir <= ow_res_dir; end
            OP_RBYTE: rdata <= ow_res_byte;
            default: ;
          endcase
        end
        if (ev_llsamp) ll <= ow_line;
      end
    end
  end

  assert_devrst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_devrst |=> (status == 8'h10 && cfg == '0 && ptr == PTR_STAT && ow_abort));
  assert_sd_ppd_R9: assert property (@(posedge clk) disable iff (!rst_n) !(sd && ppd));
  assert_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ow_start |-> $past(!busy));
  assert_spu_end_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (ow_spu_end && !ev_cfg && !ev_devrst) |=> !cfg.spu);
endmodule

// File: rtl/owm_rd_mux.sv
module owm_rd_mux
  import owm_pkg::*;
(
  input  rptr_e      ptr,
  input  logic [7:0] status,
  input  logic [7:0] rdata,
  input  cfg_t       cfg,
  output logic [7:0] tx_data
);
  always_comb begin
    case (ptr)
      PTR_DATA: tx_data = rdata;
      PTR_CFG:  tx_data = {4'b0000, cfg.ows, cfg.spu, 1'b0, cfg.apu};
      default:  tx_data = status;
    endcase
  end
endmodule

// File: rtl/owm_bridge_ctrl.sv
module owm_bridge_ctrl
  import owm_pkg::*;
#(
  parameter int AD_W = 2,
  parameter logic [6:0] ADDR_BASE = 7'b0011000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AD_W-1:0] ad_sel,
  input  logic            bus_start,
  input  logic            bus_stop,
  input  logic            rx_valid,
  input  logic [7:0]      rx_data,
  output logic            rx_ready,
  output logic            ack_valid,
  input  logic            ack_ready,
  output logic            ack_bit,
  output logic            tx_valid,
  output logic [7:0]      tx_data,
  output logic            ow_start,
  output logic [2:0]      ow_op,
  output logic [7:0]      ow_data,
  output logic            ow_abort,
  input  logic            ow_done,
  input  logic            ow_res_ppd,
  input  logic            ow_res_sd,
  input  logic            ow_res_sbr,
  input  logic            ow_res_tsb,
  input  logic            ow_res_dir,
  input  logic [7:0]      ow_res_byte,
  input  logic            ow_spu_end,
  input  logic            ow_line,
  output logic            cfg_apu,
  output logic            cfg_spu,
  output logic            cfg_ows
);
  logic       busy, ev_devrst, ev_ptr, ev_cfg, ev_start, ev_llsamp;
  rptr_e      ev_ptr_val, ptr;
  cfg_t       ev_cfg_val, cfg;
  ow_op_e     ev_op, op_q;
  logic [7:0] status, rdata;

  owm_cmd_fsm #(.AD_W(AD_W), .ADDR_BASE(ADDR_BASE)) u_fsm (
    .clk, .rst_n, .ad_sel, .bus_start, .bus_stop, .rx_valid, .rx_data, .rx_ready,
    .ack_valid, .ack_ready, .ack_bit, .tx_valid, .busy, .ptr_is_stat(ptr == PTR_STAT),
    .ev_devrst, .ev_ptr, .ev_ptr_val, .ev_cfg, .ev_cfg_val, .ev_start, .ev_op, .ev_llsamp
  );

  owm_regs u_regs (
    .clk, .rst_n, .ev_devrst, .ev_ptr, .ev_ptr_val, .ev_cfg, .ev_cfg_val, .ev_start, .ev_op,
    .ev_data(rx_data), .ev_llsamp, .ow_done, .ow_res_ppd, .ow_res_sd, .ow_res_sbr,
    .ow_res_tsb, .ow_res_dir, .ow_res_byte, .ow_spu_end, .ow_line, .cfg, .status, .rdata,
    .ptr, .busy, .ow_start, .ow_op(op_q), .ow_data, .ow_abort
  );

  owm_rd_mux u_mux (.ptr, .status, .rdata, .cfg, .tx_data);

  assign ow_op   = op_q;
  assign cfg_apu = cfg.apu;
  assign cfg_spu = cfg.spu;
  assign cfg_ows = cfg.ows;
endmodule

// File: tb/test_owm_bridge_ctrl.sv
module test_owm_bridge_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] ad_sel = 2'b10;
  logic bus_start = 0, bus_stop = 0, rx_valid = 0, ack_ready = 1;
  logic [7:0] rx_data = 0;
  logic rx_ready, ack_valid, ack_bit, tx_valid, ow_start, ow_abort;
  logic [7:0] tx_data, ow_data;
  logic [2:0] ow_op;
  logic ow_done = 0, r_ppd = 0, r_sd = 0, r_sbr = 0, r_tsb = 0, r_dir = 0, ow_spu_end = 0, ow_line = 0;
  logic [7:0] r_byte = 0;
  logic cfg_apu, cfg_spu, cfg_ows;

  owm_bridge_ctrl i_owm_bridge_ctrl (
    .clk, .rst_n, .ad_sel, .bus_start, .bus_stop, .rx_valid, .rx_data, .rx_ready, .ack_valid,
    .ack_ready, .ack_bit, .tx_valid, .tx_data, .ow_start, .ow_op, .ow_data, .ow_abort, .ow_done,
    .ow_res_ppd(r_ppd), .ow_res_sd(r_sd), .ow_res_sbr(r_sbr), .ow_res_tsb(r_tsb),
    .ow_res_dir(r_dir), .ow_res_byte(r_byte), .ow_spu_end, .ow_line, .cfg_apu, .cfg_spu, .cfg_ows
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cap_n = 0, abort_n = 0, exp_n = 0, exp_abort = 0;
  logic [2:0] cap_op;
  logic [7:0] cap_data;
  bit done_flag = 0;

  always @(negedge clk) begin
    if (ow_start) begin cap_n++; cap_op = ow_op; cap_data = ow_data; end
    if (ow_abort) abort_n++;
  end

  // reference model
  logic m_ows = 0, m_spu = 0, m_apu = 0, m_rst = 1, m_busy = 0, m_ll = 0, m_sd = 0, m_ppd = 0;
  logic m_sbr = 0, m_tsb = 0, m_dir = 0;
  logic [7:0] m_rdata = 0;
  int m_ptr = 0;
  logic [2:0] m_op = 0;
  localparam logic [7:0] ADDR_W = {5'b00110, 2'b10, 1'b0};

  function automatic logic [7:0] exp_reg();
    if (m_ptr == 1) return m_rdata;
    if (m_ptr == 2) return {4'b0, m_ows, m_spu, 1'b0, m_apu};
    return {m_dir, m_tsb, m_sbr, m_rst, m_ll, m_sd, m_ppd, m_busy};
  endfunction

  function automatic int ptr_of(input logic [7:0] pc);
    if (pc == 8'hF0) return 0;
    if (pc == 8'hE1) return 1;
    if (pc == 8'hC3) return 2;
    return -1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pstart(); bus_start = 1; @(negedge clk); bus_start = 0; endtask
  task automatic pstop();  bus_stop = 1;  @(negedge clk); bus_stop = 0;  endtask

  task automatic send(input logic [7:0] b, input logic exp_ack, input string req);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
    chk({req, " ack_valid"}, int'(ack_valid), 1);
    chk({req, " ack"}, int'(ack_bit), int'(exp_ack));
    @(negedge clk);
  endtask

  task automatic read_reg(input string req);
    pstart();
    send(ADDR_W | 8'h01, 1, "R1");
    if (m_ptr == 0) m_ll = ow_line;
    chk({req, " tx_valid"}, int'(tx_valid), 1);
    chk(req, int'(tx_data), int'(exp_reg()));
    @(negedge clk);
    chk("R11 repeat read", int'(tx_data), int'(exp_reg()));
    pstop();
  endtask

  task automatic expect_start(input logic [2:0] op, input logic [7:0] d, input logic use_d);
    exp_n++;
    chk("R6 start count", cap_n, exp_n);
    chk("R6 op", int'(cap_op), int'(op));
    if (use_d) chk("R6 data", int'(cap_data), int'(d));
    m_busy = 1; m_ptr = 0; m_op = op;
  endtask

  task automatic issue(input logic [7:0] code, input logic [7:0] par);
    pstart();
    send(ADDR_W, 1, "R1");
    case (code)
      8'hF0: begin
        send(code, 1, "R8");
        m_rst = 1; m_busy = 0; m_ll = 0; m_sd = 0; m_ppd = 0; m_sbr = 0; m_tsb = 0; m_dir = 0;
        m_ows = 0; m_spu = 0; m_apu = 0; m_ptr = 0; exp_abort++;
        chk("R8 abort", abort_n, exp_abort);
        send(par, 0, "R10 extra");
      end
      8'hE1: begin
        send(code, 1, "R7 setptr");
        send(par, ptr_of(par) >= 0, "R3");
        if (ptr_of(par) >= 0) m_ptr = ptr_of(par);
        send(8'h00, 0, "R10 extra");
      end
      8'hD2: begin
        if (m_busy) begin send(code, 0, "R7"); send(par, 0, "R10"); end
        else begin
          send(code, 1, "R4");
          send(par, par[7:4] == ~par[3:0], "R4 check");
          if (par[7:4] == ~par[3:0]) begin
            m_ows = par[3]; m_spu = par[2]; m_apu = par[0]; m_rst = 0; m_ptr = 2;
          end
        end
      end
      8'hB4, 8'h96: begin
        if (m_busy) begin send(code, 0, "R7"); chk("R7 no start", cap_n, exp_n); end
        else begin
          send(code, 1, "R6");
          expect_start(code == 8'hB4 ? 3'd0 : 3'd3, 8'h00, 0);
          send(par, 0, "R10 extra");
        end
      end
      8'h87, 8'hA5, 8'h78: begin
        if (m_busy) begin send(code, 0, "R7"); send(par, 0, "R10"); chk("R7 no start", cap_n, exp_n); end
        else begin
          send(code, 1, "R6");
          send(par, 1, "R6 param");
          expect_start(code == 8'h87 ? 3'd1 : code == 8'hA5 ? 3'd2 : 3'd4, par, 1);
        end
      end
      default: begin send(code, 0, "R10 unknown"); send(par, 0, "R10 after reject"); end
    endcase
    pstop();
  endtask

  task automatic seq_done(input logic p, input logic s, input logic b1, input logic b2,
                          input logic dr, input logic [7:0] by);
    r_ppd = p; r_sd = s; r_sbr = b1; r_tsb = b2; r_dir = dr; r_byte = by; ow_done = 1;
    @(negedge clk);
    ow_done = 0;
    if (m_busy) begin
      m_busy = 0;
      case (m_op)
        3'd0: begin m_sd = s; m_ppd = p & ~s; end
        3'd1: m_sbr = b1;
        3'd4: begin m_sbr = b1; m_tsb = b2; m_dir = dr; end
        3'd3: m_rdata = by;
        default: ;
      endcase
    end
  endtask

  task automatic spu_end();
    ow_spu_end = 1; @(negedge clk); ow_spu_end = 0; m_spu = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset state
    chk("R2 cfg pins", int'({cfg_ows, cfg_spu, cfg_apu}), 0);
    read_reg("R2 status");
    issue(8'hE1, 8'hC3);
    read_reg("R2 config");
    // R1 wrong addresses
    pstart(); send(8'h30, 0, "R1 wrong ad"); send(8'hF0, 0, "R1 ignored after"); pstop();
    pstart(); send(8'h74, 0, "R1 wrong prefix"); pstop();
    // R4 / R5
    issue(8'hD2, 8'hE3);
    read_reg("R4 bad check unchanged");
    issue(8'hD2, 8'h4B);
    read_reg("R4 readback");
    issue(8'hE1, 8'hF0);
    read_reg("R5 rst cleared");
    // R3 invalid pointer
    issue(8'hE1, 8'hE1);
    issue(8'hE1, 8'h55);
    read_reg("R3 pointer kept");
    // R6 / R7 busy window
    issue(8'hA5, 8'h3C);
    read_reg("R6 busy status");
    issue(8'hD2, 8'h2D);
    issue(8'hB4, 8'h00);
    issue(8'h87, 8'h80);
    issue(8'hE1, 8'hC3);
    read_reg("R7 cfg untouched");
    seq_done(0, 0, 0, 0, 0, 8'h00);
    // R9 results
    issue(8'hB4, 8'h00); seq_done(1, 1, 0, 0, 0, 0); read_reg("R9 short masks presence");
    issue(8'h78, 8'h80); seq_done(0, 0, 1, 0, 1, 0); read_reg("R9 triplet");
    issue(8'h96, 8'h00); seq_done(0, 0, 0, 0, 0, 8'hA7);
    issue(8'hE1, 8'hE1); read_reg("R9 read byte");
    seq_done(1, 0, 1, 1, 1, 8'h11); read_reg("R9 stray done ignored");
    // R13
    issue(8'hD2, 8'h2D); read_reg("R13 armed");
    spu_end(); read_reg("R13 spu cleared");
    // R8 device reset while busy
    issue(8'h87, 8'h00); issue(8'hF0, 8'h00); read_reg("R8 status");
    // R12 LL held during transfer
    ow_line = 1;
    pstart(); send(ADDR_W | 8'h01, 1, "R12 addr");
    m_ll = 1;
    chk("R12 ll sampled", int'(tx_data[3]), 1);
    ow_line = 0; @(negedge clk);
    chk("R12 ll held", int'(tx_data[3]), 1);
    pstop();
    // R14 back-pressure
    pstart();
    rx_valid = 1; rx_data = ADDR_W; ack_ready = 0;
    @(negedge clk); rx_valid = 0;
    chk("R14 ready low", int'(rx_ready), 0);
    @(negedge clk);
    chk("R14 ack held", int'(ack_valid), 1);
    ack_ready = 1;
    @(negedge clk);
    chk("R14 ack taken", int'(ack_valid), 0);
    chk("R14 ready back", int'(rx_ready), 1);
    pstop();
    // random mix
    for (int i = 0; i < 400; i++) begin
      int sel = $urandom % 12;
      logic [7:0] codes[8] = '{8'hF0, 8'hE1, 8'hD2, 8'hB4, 8'h87, 8'hA5, 8'h96, 8'h78};
      logic [3:0] nib = 4'($urandom);
      logic [7:0] par = 8'($urandom);
      logic [7:0] code = (sel == 0) ? 8'($urandom) : codes[$urandom % 8];
      if (code == 8'hD2 && ($urandom % 2)) par = {~nib, nib};
      if (code == 8'hE1 && ($urandom % 4) != 0) begin
        logic [7:0] pcs[3] = '{8'hF0, 8'hE1, 8'hC3};
        par = pcs[$urandom % 3];
      end
      if (sel < 6) issue(code, par);
      else if (sel < 9) seq_done(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                                 1'($urandom), 8'($urandom));
      else if (sel == 9) spu_end();
      else if (sel == 10) ow_line = 1'($urandom);
      else read_reg("R9 random read");
    end
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule